// File: doc/BRIEF.md
# Gated UART Transmitter

This block is the transmit half of a serial port. Bytes are written into a sixteen-entry holding queue and leave it one at a time through a shift register that drives the serial line. Each character is framed as a low start bit, eight data bits sent least significant first, an optional parity bit and one or two high stop bits. Every bit lasts one period of an external baud tick. The block does not generate the tick.

A single transmit-permit register acts at the point where a byte moves from the queue into the shift register. Surrounding logic clears it when the far end asks for a pause, for example when a clear-to-send line drops or an XOFF byte (0x13) arrives. The same logic sets it again on resume, for example when clear-to-send returns or an XON byte (0x11) arrives. The block has no flow-control detection of its own. A character already on the line always finishes. Writes into the queue go on being accepted while the permit is off, and the queued bytes leave in order once it is back on.

Top module: `uart_tx_gated`

## Requirements
- R1: After reset, txd is 1, tx_idle is 1, fifo_full is 0 and overrun is 0. The transmit permit resets to open, so a byte written after reset is sent without any gate write.
- R2: A character is sent as: one 0 start bit, then data bits 0 to 7 in that order, then a parity bit only if par_en=1, then a 1 stop bit, then a second 1 stop bit only if stop2=1. The parity bit is the XOR of the data bits when par_odd=0 (even) and its inverse when par_odd=1 (odd). Each bit lasts one baud tick period. par_en, par_odd and stop2 are sampled when the character starts.
- R3: While the permit is open and the queue holds data, characters follow each other with no idle bit between the last stop bit of one and the start bit of the next.
- R4: Closing the permit while a character is on the line does not shorten it. All of its bits, stop bits included, are sent.
- R5: While the permit is closed, no new character starts and txd stays 1. Writes are still accepted into the queue.
- R6: Bytes queued while the permit is closed leave in write order once it reopens, back to back with no idle bit between them.
- R7: tx_idle is 1 exactly when the queue is empty and no character is on the line. When it is 1, txd is 1.
- R8: The queue holds 16 bytes, and fifo_full is 1 while it holds 16. A write while fifo_full is 1 is dropped and sets overrun, which stays 1 until reset.
- R9: txd changes only on clock edges where baud_tick is 1. With no ticks, a written byte does not start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | One-cycle pulse marking each bit boundary |
| wr_valid | input | 1 | Write strobe for wr_byte |
| wr_byte | input | 8 | Byte to queue |
| gate_wr | input | 1 | Load gate_val into the transmit permit |
| gate_val | input | 1 | New permit value (1 = open) |
| par_en | input | 1 | Add a parity bit |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| stop2 | input | 1 | 1 = two stop bits, 0 = one |
| txd | output | 1 | Serial line, idles high |
| fifo_full | output | 1 | Queue holds 16 bytes |
| overrun | output | 1 | Sticky flag for a dropped write |
| tx_idle | output | 1 | Queue and shift register both empty |

## Verification
A write strobe sampled on one edge shows on fifo_full and tx_idle from that edge, so the bench reads those flags on the falling edge that follows its write. The line responds only on tick edges. A new character starts on the first tick edge at which the queue holds data and the permit is open, and each later bit follows one tick after the one before. Because of this, the bench does not predict absolute times for the line. It records the txd value once after every tick edge and compares the recorded stream bit for bit with the frames the requirements predict, counting the idle bits between frames to check back-to-back sending.

// File: rtl/uart_txg_pkg.sv
package uart_txg_pkg;

  typedef struct packed {
    logic par_en;
    logic par_odd;
    logic stop2;
  } txg_cfg_t;

  // number of line bits for a character of dw data bits under cfg
  function automatic int unsigned txg_frame_len(input int unsigned dw, input txg_cfg_t cfg);
    return dw + 2 + int'(cfg.par_en) + int'(cfg.stop2);
  endfunction

endpackage

// File: rtl/txg_fifo.sv
module txg_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_req,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_req,
  output logic [DW-1:0] rd_data,
  output logic          empty,
  output logic          full,
  output logic          overrun
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_C  = AW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count, count_nx;
  logic          do_wr, do_rd;

  assign do_wr = wr_req && !full;
  assign do_rd = rd_req && !empty;

  always_comb begin
    count_nx = count;
    if (do_wr && !do_rd) count_nx = count + 1'b1;
    else if (do_rd && !do_wr) count_nx = count - 1'b1;
  end

  // storage write port without reset, so a RAM primitive can hold it
  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr] <= wr_data;
  end

  assign rd_data = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count   <= '0;
      empty   <= 1'b1;
      full    <= 1'b0;
      overrun <= 1'b0;
    end else begin
      if (do_wr) wr_ptr <= (wr_ptr == LAST_C) ? '0 : wr_ptr + 1'b1;
      if (do_rd) rd_ptr <= (rd_ptr == LAST_C) ? '0 : rd_ptr + 1'b1;
      count <= count_nx;
      empty <= (count_nx == '0);
      full  <= (count_nx == DEPTH_C);
      if (wr_req && full) overrun <= 1'b1;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (full && wr_req && !rd_req) |=> $stable(count)); // R8
  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun); // R8
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    count <= DEPTH_C); // R8

endmodule

// File: rtl/txg_shifter.sv
module txg_shifter
  import uart_txg_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          gate,
  input  logic          avail,
  input  logic [DW-1:0] din,
  input  txg_cfg_t      cfg,
  output logic          pop,
  output logic          txd,
  output logic          busy
);
  // bits after the start bit: data, parity slot, two stop slots
  localparam int SW = DW + 3;
  localparam int LW = $clog2(SW + 2);

  logic [SW-1:0] sh;
  logic [SW-1:0] load_val;
  logic [LW-1:0] left;
  logic          par_bit;
  logic          handoff;

  always_comb begin
    par_bit = cfg.par_odd ? ~(^din) : (^din);
    if (cfg.par_en) load_val = {2'b11, par_bit, din};
    else            load_val = {3'b111, din};
  end

  // a new character may only be taken when the line is free or its last bit ends
  assign handoff = (left <= LW'(1));
  assign pop     = tick && handoff && avail && gate;
  assign busy    = (left != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      txd  <= 1'b1;
      left <= '0;
      sh   <= '1;
    end else if (tick) begin
      if (handoff) begin
        if (avail && gate) begin
          txd  <= 1'b0;
          sh   <= load_val;
          left <= LW'(txg_frame_len(DW, cfg));
        end else begin
          txd  <= 1'b1;
          left <= '0;
        end
      end else begin
        txd  <= sh[0];
        sh   <= {1'b1, sh[SW-1:1]};
        left <= left - 1'b1;
      end
    end
  end

  AST_TXD_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(txd)); // R9
  AST_FRAME_FINISHES: assert property (@(posedge clk) disable iff (rst)
    (left > LW'(1)) |=> (left != '0)); // R4
  AST_CLOSED_GATE_HOLDS_LINE: assert property (@(posedge clk) disable iff (rst)
    (left == '0 && !gate) |=> txd); // R5

endmodule

// File: rtl/uart_tx_gated.sv
module uart_tx_gated
  import uart_txg_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          baud_tick,
  input  logic          wr_valid,
  input  logic [DW-1:0] wr_byte,
  input  logic          gate_wr,
  input  logic          gate_val,
  input  logic          par_en,
  input  logic          par_odd,
  input  logic          stop2,
  output logic          txd,
  output logic          fifo_full,
  output logic          overrun,
  output logic          tx_idle
);
  logic          gate_q;
  logic          q_empty;
  logic          pop;
  logic          busy;
  logic [DW-1:0] q_data;
  txg_cfg_t      cfg;

  assign cfg = '{par_en: par_en, par_odd: par_odd, stop2: stop2};

  // transmit permit: open out of reset
  always_ff @(posedge clk) begin
    if (rst)          gate_q <= 1'b1;
    else if (gate_wr) gate_q <= gate_val;
  end

  txg_fifo #(.DW(DW), .DEPTH(DEPTH)) i_fifo (
    .clk     (clk),
    .rst     (rst),
    .wr_req  (wr_valid),
    .wr_data (wr_byte),
    .rd_req  (pop),
    .rd_data (q_data),
    .empty   (q_empty),
    .full    (fifo_full),
    .overrun (overrun)
  );

  txg_shifter #(.DW(DW)) i_shift (
    .clk   (clk),
    .rst   (rst),
    .tick  (baud_tick),
    .gate  (gate_q),
    .avail (!q_empty),
    .din   (q_data),
    .cfg   (cfg),
    .pop   (pop),
    .txd   (txd),
    .busy  (busy)
  );

  assign tx_idle = q_empty && !busy;

  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (rst)
    tx_idle |-> txd); // R7

endmodule

// File: tb/test_uart_tx_gated.sv
module test_uart_tx_gated;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       baud_tick = 1'b0;
  logic       wr_valid = 1'b0;
  logic [7:0] wr_byte = '0;
  logic       gate_wr = 1'b0, gate_val = 1'b1;
  logic       par_en = 1'b0, par_odd = 1'b0, stop2 = 1'b0;
  logic       txd, fifo_full, overrun, tx_idle;

  int checks = 0, fails = 0;
  bit tick_run = 1'b0;
  bit tick_seen = 1'b0;
  localparam int LOGN = 16384;
  logic log_bits [LOGN];
  int nlog = 0, rdp = 0;

  uart_tx_gated i_uart_tx_gated (
    .clk(clk), .rst(rst), .baud_tick(baud_tick), .wr_valid(wr_valid),
    .wr_byte(wr_byte), .gate_wr(gate_wr), .gate_val(gate_val),
    .par_en(par_en), .par_odd(par_odd), .stop2(stop2), .txd(txd),
    .fifo_full(fifo_full), .overrun(overrun), .tx_idle(tx_idle));

  always #10 clk = ~clk;

  initial begin
    int div = 0;
    forever begin
      @(negedge clk);
      if (tick_run) begin
        baud_tick = (div == 3);
        div = (div + 1) % 4;
      end else begin
        baud_tick = 1'b0;
        div = 0;
      end
    end
  end

  always @(posedge clk) tick_seen <= baud_tick;
  always @(negedge clk) begin
    if (tick_seen && nlog < LOGN) begin
      log_bits[nlog] = txd;
      nlog++;
    end
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] d);
    @(negedge clk); wr_valid = 1'b1; wr_byte = d;
    @(negedge clk); wr_valid = 1'b0;
  endtask

  task automatic set_gate(input bit v);
    @(negedge clk); gate_wr = 1'b1; gate_val = v;
    @(negedge clk); gate_wr = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (!tx_idle);
    repeat (8) @(negedge clk);
  endtask

  // compare the next frame in the line log; max_gap < 0 leaves the gap unchecked
  task automatic expect_frame(input logic [7:0] d, input bit pe, input bit po, input bit s2,
                              input string req, input int max_gap);
    logic [11:0] exp_f, got_f;
    int len, gap;
    exp_f = '1; got_f = '1;
    exp_f[0] = 1'b0;
    exp_f[8:1] = d;
    len = 9;
    if (pe) begin exp_f[9] = po ? ~(^d) : (^d); len++; end
    len += s2 ? 2 : 1;
    gap = 0;
    forever begin
      while (nlog <= rdp) @(negedge clk);
      if (log_bits[rdp] === 1'b0) break;
      rdp++; gap++;
      if (gap > 3000) break;
    end
    if (gap > 3000) begin
      check(1'b0, req, "no start bit", 1, 0);
      return;
    end
    while (nlog < rdp + len) @(negedge clk);
    for (int i = 0; i < len; i++) got_f[i] = log_bits[rdp + i];
    rdp += len;
    check(got_f == exp_f, req, $sformatf("frame for %02h", d), int'(got_f), int'(exp_f));
    if (max_gap >= 0)
      check(gap <= max_gap, req, "idle bits before frame", gap, max_gap);
  endtask

  task automatic expect_silent(input int n, input string req);
    int ones = 0;
    while (nlog < rdp + n) @(negedge clk);
    for (int i = 0; i < n; i++) if (log_bits[rdp + i] === 1'b1) ones++;
    rdp += n;
    check(ones == n, req, "high line bits", ones, n);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(txd === 1'b1, "R1", "txd after reset", int'(txd), 1);
    check(tx_idle === 1'b1, "R1", "tx_idle after reset", int'(tx_idle), 1);
    check(fifo_full === 1'b0, "R1", "fifo_full after reset", int'(fifo_full), 0);
    check(overrun === 1'b0, "R1", "overrun after reset", int'(overrun), 0);
    tick_run = 1'b1;
  endtask

  task automatic t_single();
    put(8'hA5);
    check(tx_idle === 1'b0, "R7", "tx_idle after write", int'(tx_idle), 0);
    expect_frame(8'hA5, 0, 0, 0, "R1", -1);
    wait_idle();
    check(tx_idle === 1'b1, "R7", "tx_idle after frame", int'(tx_idle), 1);
  endtask

  task automatic t_framing();
    par_en = 1'b1; par_odd = 1'b0; stop2 = 1'b1;
    put(8'h37);
    expect_frame(8'h37, 1, 0, 1, "R2", -1);
    wait_idle();
    par_odd = 1'b1; stop2 = 1'b0;
    put(8'h37);
    expect_frame(8'h37, 1, 1, 0, "R2", -1);
    wait_idle();
    put(8'h00);
    expect_frame(8'h00, 1, 1, 0, "R2", -1);
    wait_idle();
    par_en = 1'b0; par_odd = 1'b0; stop2 = 1'b0;
  endtask

  task automatic t_burst();
    put(8'h11); put(8'h80); put(8'hFE);
    expect_frame(8'h11, 0, 0, 0, "R3", -1);
    expect_frame(8'h80, 0, 0, 0, "R3", 0);
    expect_frame(8'hFE, 0, 0, 0, "R3", 0);
    wait_idle();
  endtask

  task automatic t_gate_mid();
    put(8'h5A);
    do @(negedge clk); while (txd !== 1'b0);
    set_gate(1'b0);
    put(8'hC3); put(8'h13);
    expect_frame(8'h5A, 0, 0, 0, "R4", -1);
    expect_silent(30, "R5");
    check(tx_idle === 1'b0, "R7", "tx_idle with queued data", int'(tx_idle), 0);
    check(txd === 1'b1, "R5", "txd while closed", int'(txd), 1);
    set_gate(1'b1);
    expect_frame(8'hC3, 0, 0, 0, "R6", -1);
    expect_frame(8'h13, 0, 0, 0, "R6", 0);
    wait_idle();
  endtask

  task automatic t_full();
    set_gate(1'b0);
    for (int i = 0; i < 16; i++) put(8'(i * 7 + 3));
    check(fifo_full === 1'b1, "R8", "fifo_full at 16", int'(fifo_full), 1);
    check(overrun === 1'b0, "R8", "overrun before drop", int'(overrun), 0);
    check(txd === 1'b1, "R5", "txd with full queue closed", int'(txd), 1);
    put(8'hEE);
    check(overrun === 1'b1, "R8", "overrun after drop", int'(overrun), 1);
    set_gate(1'b1);
    for (int i = 0; i < 16; i++)
      expect_frame(8'(i * 7 + 3), 0, 0, 0, "R8", (i == 0) ? -1 : 0);
    expect_silent(20, "R8");
    check(overrun === 1'b1, "R8", "overrun stays set", int'(overrun), 1);
    check(tx_idle === 1'b1, "R7", "tx_idle after drain", int'(tx_idle), 1);
  endtask

  task automatic t_no_tick();
    int high = 0;
    tick_run = 1'b0;
    repeat (3) @(negedge clk);
    put(8'h3C);
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (txd === 1'b1) high++;
    end
    check(high == 30, "R9", "line high without ticks", high, 30);
    rdp = nlog;
    tick_run = 1'b1;
    expect_frame(8'h3C, 0, 0, 0, "R9", -1);
    wait_idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_single();
    t_framing();
    t_burst();
    t_gate_mid();
    t_full();
    t_no_tick();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule